// File: doc/BRIEF.md
# Dual-Port RAM with Busy Arbitration

This block is a synchronous dual-port memory. It has two independent access ports, called left and right. Each port has its own address bus, write data, read data, read/write strobe, active-low output enable and a pair of chip enables. Either port can read or write any word in any cycle. A port is selected only when its active-low enable is low and its active-high enable is high. Reads are registered: the addressed word appears one clock after the request, together with a drive-enable flag. When the flag is low, the read data bus is held at zero, which stands in for an undriven bus.

When both ports are selected at the same address in the same cycle, a fixed-priority arbiter gives the cycle to the left port. It raises a busy flag toward the right port and drops the right port's write. A strap input chooses the busy source. As master, the block makes busy itself and drives it out. As slave, it drives its busy outputs low, and externally supplied busy inputs block its writes instead. Several devices can then be cascaded to widen the data word, with all of them agreeing on who wins. The busy outputs are always driven with a defined level.

Top module: `dual_port_ram`

## Requirements
- R1: The store holds 2**ADDR_W words of DATA_W bits (ADDR_W=15, DATA_W=9 gives 32768 nine-bit words). Every address up to the top one, all ones, is writable and readable from both ports.
- R2: A port is selected only when its `ce0_n` is 0 and its `ce1` is 1. With any other enable combination the port neither writes nor reads, and its `dout_en` is 0 on the next cycle.
- R3: A selected port with `rw` = 0 writes `din` to the addressed word whatever the level of `oe_n`. The port does not read in that cycle, so `dout_en` is 0 on the next cycle.
- R4: A selected port with `rw` = 1 and `oe_n` = 0 presents the addressed word on `dout` one clock after the request, with `dout_en` = 1. Whenever `dout_en` is 0, `dout` is zero.
- R5: With `oe_n` = 1 the port's read data is not driven: `dout_en` is 0 and `dout` is zero on the next cycle, whatever the other controls are.
- R6: With `ms_master` = 1, if both ports are selected at the same address in one cycle, `r_busy_o` is 1 in that cycle, `l_busy_o` stays 0, and the right port's write is dropped. The left port's write lands, and reads on either port are still served. Otherwise both busy outputs are 0.
- R7: With `ms_master` = 0, both busy outputs are 0. A port whose busy input (`l_busy_i`, `r_busy_i`) is 1 has its write dropped. Same-address collisions are not suppressed internally; if both ports write the same word, the left port's data remains.
- R8: With `ms_master` = 1, the busy inputs have no effect on writes.
- R9: While `rst_n` is 0 and after its release, both `dout_en` outputs are 0 and both `dout` buses are zero until a read is requested.
- R10: A read that shares a cycle with a write to the same word returns the word as it was before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_master | input | 1 | 1: busy is produced and driven out; 0: busy is taken from inputs |
| l_ce0_n | input | 1 | Left active-low chip enable |
| l_ce1 | input | 1 | Left active-high chip enable |
| l_rw | input | 1 | Left strobe: 1 read, 0 write |
| l_oe_n | input | 1 | Left active-low output enable |
| l_addr | input | ADDR_W | Left word address |
| l_din | input | DATA_W | Left write data |
| l_dout | output | DATA_W | Left registered read data, zero when not driven |
| l_dout_en | output | 1 | Left read data driven/valid |
| l_busy_i | input | 1 | Left external busy (slave mode) |
| l_busy_o | output | 1 | Left busy flag (master mode) |
| r_ce0_n | input | 1 | Right active-low chip enable |
| r_ce1 | input | 1 | Right active-high chip enable |
| r_rw | input | 1 | Right strobe: 1 read, 0 write |
| r_oe_n | input | 1 | Right active-low output enable |
| r_addr | input | ADDR_W | Right word address |
| r_din | input | DATA_W | Right write data |
| r_dout | output | DATA_W | Right registered read data, zero when not driven |
| r_dout_en | output | 1 | Right read data driven/valid |
| r_busy_i | input | 1 | Right external busy (slave mode) |
| r_busy_o | output | 1 | Right busy flag (master mode) |

## Verification
Three things can fall on the same cycle: a left access, a right access to the same word, and a write by one port while the other reads. The bench provokes each case by driving both ports with equal addresses in one cycle. It reads `r_busy_o` and `l_busy_o` between edges, in the same cycle as the collision, and reads the word back afterwards to see whose data landed. The read-under-write case is judged by the data the reading port returns on the following cycle, which must be the old word. The slave-mode cases repeat the same collisions with the strap low, so that only the external busy inputs decide.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

  typedef struct packed {
    logic sel;   // port enabled by both chip enables
    logic wr;    // write request
    logic rd;    // read request with output enabled
  } port_req_t;

  function automatic logic port_selected(input logic ce0_n, input logic ce1);
    return (!ce0_n) && ce1;
  endfunction

  function automatic port_req_t decode_req(input logic ce0_n, input logic ce1,
                                           input logic rw, input logic oe_n);
    port_req_t q;
    q.sel = port_selected(ce0_n, ce1);
    q.wr  = q.sel && !rw;
    q.rd  = q.sel && rw && !oe_n;
    return q;
  endfunction

endpackage

// File: rtl/dpr_port_decode.sv
module dpr_port_decode
  import dpr_pkg::*;
(
  input  logic      ce0_n,
  input  logic      ce1,
  input  logic      rw,
  input  logic      oe_n,
  output port_req_t req
);

  assign req = decode_req(ce0_n, ce1, rw, oe_n);

endmodule

// File: rtl/dpr_arbiter.sv
module dpr_arbiter
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ms_master,
  input  port_req_t         l_req,
  input  port_req_t         r_req,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              l_busy_i,
  input  logic              r_busy_i,
  output logic              l_wr_ok,
  output logic              r_wr_ok,
  output logic              l_busy_o,
  output logic              r_busy_o
);

  logic same_word;
  logic collide;
  logic l_blocked;
  logic r_blocked;

  assign same_word = (l_addr == r_addr);
  assign collide   = l_req.sel && r_req.sel && same_word;

  always_comb begin
    if (ms_master) begin
      l_blocked = 1'b0;
      r_blocked = collide;
    end else begin
      l_blocked = l_busy_i;
      r_blocked = r_busy_i;
    end
  end

  assign l_wr_ok  = l_req.wr && !l_blocked;
  assign r_wr_ok  = r_req.wr && !r_blocked;
  assign l_busy_o = 1'b0;
  assign r_busy_o = ms_master && collide;

  AST_MASTER_NO_DOUBLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ms_master |-> !(l_wr_ok && r_wr_ok && same_word)); // R6

  AST_MASTER_LEFT_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    (ms_master && l_req.wr) |-> l_wr_ok); // R8

  AST_SLAVE_BUSY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !ms_master |-> (!l_busy_o && !r_busy_o)); // R7

  AST_SLAVE_INPUT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ms_master && r_busy_i) |-> !r_wr_ok); // R7

endmodule

// File: rtl/dpr_mem_core.sv
module dpr_mem_core #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_we,
  input  logic              r_we,
  input  logic              l_re,
  input  logic              r_re,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] l_din,
  input  logic [DATA_W-1:0] r_din,
  output logic [DATA_W-1:0] l_dout,
  output logic [DATA_W-1:0] r_dout,
  output logic              l_dout_en,
  output logic              r_dout_en
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  // right first, left last: left data remains on a same-word double write
  always_ff @(posedge clk) begin
    if (r_we) store[r_addr] <= r_din;
    if (l_we) store[l_addr] <= l_din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_dout    <= '0;
      r_dout    <= '0;
      l_dout_en <= 1'b0;
      r_dout_en <= 1'b0;
    end else begin
      l_dout_en <= l_re;
      r_dout_en <= r_re;
      l_dout    <= l_re ? store[l_addr] : '0;
      r_dout    <= r_re ? store[r_addr] : '0;
    end
  end

  AST_READ_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    l_re |=> l_dout_en); // R4

  AST_NO_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !r_re |=> (!r_dout_en && r_dout == '0)); // R5

  AST_UNDRIVEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !l_dout_en |-> (l_dout == '0)); // R4

endmodule

// File: rtl/dual_port_ram.sv
module dual_port_ram
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ms_master,
  input  logic              l_ce0_n,
  input  logic              l_ce1,
  input  logic              l_rw,
  input  logic              l_oe_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_din,
  output logic [DATA_W-1:0] l_dout,
  output logic              l_dout_en,
  input  logic              l_busy_i,
  output logic              l_busy_o,
  input  logic              r_ce0_n,
  input  logic              r_ce1,
  input  logic              r_rw,
  input  logic              r_oe_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_din,
  output logic [DATA_W-1:0] r_dout,
  output logic              r_dout_en,
  input  logic              r_busy_i,
  output logic              r_busy_o
);

  port_req_t l_req;
  port_req_t r_req;
  logic      l_wr_ok;
  logic      r_wr_ok;

  dpr_port_decode u_l_dec (
    .ce0_n (l_ce0_n), .ce1 (l_ce1), .rw (l_rw), .oe_n (l_oe_n), .req (l_req)
  );

  dpr_port_decode u_r_dec (
    .ce0_n (r_ce0_n), .ce1 (r_ce1), .rw (r_rw), .oe_n (r_oe_n), .req (r_req)
  );

  dpr_arbiter #(.ADDR_W(ADDR_W)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .ms_master (ms_master),
    .l_req     (l_req),
    .r_req     (r_req),
    .l_addr    (l_addr),
    .r_addr    (r_addr),
    .l_busy_i  (l_busy_i),
    .r_busy_i  (r_busy_i),
    .l_wr_ok   (l_wr_ok),
    .r_wr_ok   (r_wr_ok),
    .l_busy_o  (l_busy_o),
    .r_busy_o  (r_busy_o)
  );

  dpr_mem_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk       (clk),
    .rst_n     (rst_n),
    .l_we      (l_wr_ok),
    .r_we      (r_wr_ok),
    .l_re      (l_req.rd),
    .r_re      (r_req.rd),
    .l_addr    (l_addr),
    .r_addr    (r_addr),
    .l_din     (l_din),
    .r_din     (r_din),
    .l_dout    (l_dout),
    .r_dout    (r_dout),
    .l_dout_en (l_dout_en),
    .r_dout_en (r_dout_en)
  );

  AST_DESELECT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !port_selected(l_ce0_n, l_ce1) |=> !l_dout_en); // R2

  AST_OE_HIGH_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    r_oe_n |=> !r_dout_en); // R5

  AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !l_rw |=> !l_dout_en); // R3

  AST_LEFT_NEVER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !l_busy_o); // R6

endmodule

// File: tb/test_dual_port_ram.sv
module test_dual_port_ram;

  localparam int AW = 10;
  localparam int DW = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ms_master = 1'b1;
  logic l_ce0_n, l_ce1, l_rw, l_oe_n, l_busy_i;
  logic r_ce0_n, r_ce1, r_rw, r_oe_n, r_busy_i;
  logic [AW-1:0] l_addr, r_addr;
  logic [DW-1:0] l_din, r_din;
  logic [DW-1:0] l_dout, r_dout;
  logic l_dout_en, r_dout_en, l_busy_o, r_busy_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dual_port_ram #(.ADDR_W(AW), .DATA_W(DW)) i_dual_port_ram (
    .clk(clk), .rst_n(rst_n), .ms_master(ms_master),
    .l_ce0_n(l_ce0_n), .l_ce1(l_ce1), .l_rw(l_rw), .l_oe_n(l_oe_n),
    .l_addr(l_addr), .l_din(l_din), .l_dout(l_dout), .l_dout_en(l_dout_en),
    .l_busy_i(l_busy_i), .l_busy_o(l_busy_o),
    .r_ce0_n(r_ce0_n), .r_ce1(r_ce1), .r_rw(r_rw), .r_oe_n(r_oe_n),
    .r_addr(r_addr), .r_din(r_din), .r_dout(r_dout), .r_dout_en(r_dout_en),
    .r_busy_i(r_busy_i), .r_busy_o(r_busy_o)
  );

  // [33] port(0 L,1 R) [32] ce0_n [31] ce1 [30] rw [29] oe_n
  // [28:19] addr [18:10] din [9] exp_en [8:0] exp_dout
  localparam int NV = 11;
  localparam logic [33:0] VT [NV] = '{
    {1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 10'd5,   9'h1A5, 1'b0, 9'h000}, // R3 write, oe high
    {1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 10'd5,   9'h000, 1'b1, 9'h1A5}, // R4 left read
    {1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 10'd5,   9'h000, 1'b1, 9'h1A5}, // R4 right read
    {1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 10'h3FF, 9'h0F0, 1'b0, 9'h000}, // R1 top word write
    {1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 10'h3FF, 9'h000, 1'b1, 9'h0F0}, // R1 top word read
    {1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 10'h3FF, 9'h000, 1'b0, 9'h000}, // R5 oe high
    {1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 10'd5,   9'h000, 1'b0, 9'h000}, // R2 ce0_n high
    {1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 10'd5,   9'h000, 1'b0, 9'h000}, // R2 ce1 low write
    {1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 10'd5,   9'h000, 1'b1, 9'h1A5}, // R2 word unchanged
    {1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 10'd0,   9'h1FF, 1'b0, 9'h000}, // R3 write, oe low
    {1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 10'd0,   9'h000, 1'b1, 9'h1FF}  // R1 bottom word read
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    l_ce0_n = 1'b1; l_ce1 = 1'b0; l_rw = 1'b1; l_oe_n = 1'b1;
    r_ce0_n = 1'b1; r_ce1 = 1'b0; r_rw = 1'b1; r_oe_n = 1'b1;
    l_addr = '0; r_addr = '0; l_din = '0; r_din = '0;
  endtask

  task automatic drv_l(input logic rw, input logic [AW-1:0] a, input logic [DW-1:0] d);
    l_ce0_n = 1'b0; l_ce1 = 1'b1; l_rw = rw; l_oe_n = 1'b0; l_addr = a; l_din = d;
  endtask

  task automatic drv_r(input logic rw, input logic [AW-1:0] a, input logic [DW-1:0] d);
    r_ce0_n = 1'b0; r_ce1 = 1'b1; r_rw = rw; r_oe_n = 1'b0; r_addr = a; r_din = d;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic rd_l(input logic [AW-1:0] a, input int exp, input string tag);
    @(negedge clk); idle(); drv_l(1'b1, a, '0);
    tick();
    chk(tag, {l_dout_en, l_dout}, {1'b1, exp[DW-1:0]});
  endtask

  task automatic rd_r(input logic [AW-1:0] a, input int exp, input string tag);
    @(negedge clk); idle(); drv_r(1'b1, a, '0);
    tick();
    chk(tag, {r_dout_en, r_dout}, {1'b1, exp[DW-1:0]});
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    idle();
    l_busy_i = 1'b0; r_busy_i = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R9 reset left", {l_dout_en, l_dout}, 0);
    chk("R9 reset right", {r_dout_en, r_dout}, 0);
    @(negedge clk); rst_n = 1'b1;
    tick();
    chk("R9 after release", {l_dout_en, l_dout, r_dout_en, r_dout}, 0);

    for (int i = 0; i < NV; i++) begin
      logic [33:0] v;
      v = VT[i];
      @(negedge clk); idle();
      if (!v[33]) begin
        l_ce0_n = v[32]; l_ce1 = v[31]; l_rw = v[30]; l_oe_n = v[29];
        l_addr = v[28:19]; l_din = v[18:10];
      end else begin
        r_ce0_n = v[32]; r_ce1 = v[31]; r_rw = v[30]; r_oe_n = v[29];
        r_addr = v[28:19]; r_din = v[18:10];
      end
      tick();
      if (!v[33]) chk($sformatf("R1-table vec %0d left", i), {l_dout_en, l_dout}, v[9:0]);
      else        chk($sformatf("R1-table vec %0d right", i), {r_dout_en, r_dout}, v[9:0]);
    end

    // R6 master collision: both write word 7
    @(negedge clk); idle(); drv_l(1'b0, 10'd7, 9'h011); drv_r(1'b0, 10'd7, 9'h122);
    #1;
    chk("R6 right busy on collision", r_busy_o, 1);
    chk("R6 left never busy", l_busy_o, 0);
    tick();
    rd_l(10'd7, 9'h011, "R6 left data wins");

    // R6 different words: no busy, both land
    @(negedge clk); idle(); drv_l(1'b0, 10'd8, 9'h0AA); drv_r(1'b0, 10'd9, 9'h055);
    #1;
    chk("R6 no busy on different words", {l_busy_o, r_busy_o}, 0);
    tick();
    rd_r(10'd8, 9'h0AA, "R6 left write landed");
    rd_l(10'd9, 9'h055, "R6 right write landed");

    // R6 read/read collision still served
    @(negedge clk); idle(); drv_l(1'b1, 10'd7, '0); drv_r(1'b1, 10'd7, '0);
    #1;
    chk("R6 busy on read collision", r_busy_o, 1);
    tick();
    chk("R6 right read served under busy", {r_dout_en, r_dout}, {1'b1, 9'h011});

    // R10 left write while right reads same word: old data returned
    @(negedge clk); idle(); drv_l(1'b0, 10'd7, 9'h033); drv_r(1'b1, 10'd7, '0);
    tick();
    chk("R10 read before write", {r_dout_en, r_dout}, {1'b1, 9'h011});
    rd_r(10'd7, 9'h033, "R10 write then landed");

    // R8 master ignores busy inputs
    @(negedge clk); idle(); l_busy_i = 1'b1; r_busy_i = 1'b1;
    drv_l(1'b0, 10'd11, 9'h0C3); drv_r(1'b0, 10'd12, 9'h13C);
    tick();
    l_busy_i = 1'b0; r_busy_i = 1'b0;
    rd_l(10'd11, 9'h0C3, "R8 left busy_i ignored");
    rd_l(10'd12, 9'h13C, "R8 right busy_i ignored");

    // R7 slave mode
    @(negedge clk); idle(); ms_master = 1'b0; r_busy_i = 1'b1;
    drv_r(1'b0, 10'd9, 9'h1EE); drv_l(1'b0, 10'd9, 9'h0EE);
    #1;
    chk("R7 slave busy outputs low", {l_busy_o, r_busy_o}, 0);
    tick();
    r_busy_i = 1'b0;
    rd_l(10'd9, 9'h0EE, "R7 left writes, right blocked");
    @(negedge clk); idle(); l_busy_i = 1'b1; drv_l(1'b0, 10'd9, 9'h001);
    tick();
    l_busy_i = 1'b0;
    rd_r(10'd9, 9'h0EE, "R7 left busy_i blocks write");
    @(negedge clk); idle(); drv_l(1'b0, 10'd10, 9'h0B0); drv_r(1'b0, 10'd10, 9'h10B);
    #1;
    chk("R7 no internal busy in slave", r_busy_o, 0);
    tick();
    rd_r(10'd10, 9'h0B0, "R7 left data remains");

    done = 1'b1;
    summary();
  end

endmodule